// File: doc/BRIEF.md
# Programmable parallel port controller

This block gives a processor three parallel ports behind a small register window on an 8-bit bus. Ports A and B are eight bits wide and port C is six. A 3-bit select input chooses the target. Active-low read and write strobes qualify each access; the bus is sampled on the rising clock edge.

Select 000 is shared by two registers. A write there loads the control word. A read there returns the status word, so the control word itself cannot be read back. The control word sets:

- the direction of ports A and B,
- one of four port C configurations,
- an interrupt enable for each of ports A and B.

Two of the port C configurations give the pins a handshake role. In those configurations a falling edge on a strobe pin latches incoming data, or acknowledges outgoing data. Buffer-full and interrupt flags are driven back out on port C pins.

The counter/timer occupies selects 100 and 101 but lives in a separate block. Its status bit enters here only to be reported in the status word.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset all output enables are low (`pa_oe`, `pb_oe` and every bit of `pc_oe`), both interrupt enables are off, and a status read returns 0x00 when `timer_stat` is low.
- R2: A write with select 000 loads the control word. Bit 0 sets port A direction and bit 1 sets port B direction, with 1 meaning output; `pa_oe` and `pb_oe` follow from the next cycle. A read at select 000 returns the status word, never the control word.
- R3: Control bits 3:2 choose the port C configuration, and `pc_oe` then reads as follows:

  | Bits 3:2 | Configuration | `pc_oe` |
  |---|---|---|
  | 00 | all inputs | 0x00 |
  | 11 | all outputs | 0x3F |
  | 01 | port A handshake: PC0 interrupt, PC1 buffer-full, PC2 strobe input, PC5..PC3 plain outputs | 0x3B |
  | 10 | handshake on both ports: PC0..PC2 for A, PC3 interrupt, PC4 buffer-full and PC5 strobe for B | 0x1B |

- R4: Writes to select 001, 010 and 011 store data. The data is driven on `pa_out`, `pb_out`, and on the plain-output bits of `pc_out`. A read of an output port returns the stored value.
- R5: A read of port A or B in input direction outside handshake returns the live pins. A read of port C (select 011) returns the pin value on input bits and the driven value on output bits, with bits 7:6 zero.
- R6: In input handshake, a falling edge on the strobe pin (PC2 for A, PC5 for B) latches the port pins and sets buffer-full. A later port read returns the latched byte even after the pins change.
- R7: Control bit 5 enables the port A interrupt and bit 4 the port B interrupt. On a strobe edge an interrupt flag is set only when its enable is on.
- R8: In input handshake, a read of the port clears its buffer-full and interrupt flags.
- R9: In output handshake, a port write sets buffer-full and clears the interrupt. A falling strobe edge then clears buffer-full and sets the interrupt if enabled.
- R10: Writes to selects 100..111 change nothing in this block, and reads there return 0x00.
- R11: The status word is laid out as follows:

  | Bit | Content |
  |---|---|
  | 0 | A interrupt |
  | 1 | A buffer-full |
  | 2 | A enable |
  | 3 | B interrupt |
  | 4 | B buffer-full |
  | 5 | B enable |
  | 6 | `timer_stat` |
  | 7 | 0 |

- R12: Port B has handshake only in configuration 10. In configuration 01 a PC5 edge leaves the port B flags at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Register select |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when no read |
| timer_stat | input | 1 | Timer status from the timer block |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output data |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output data |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 6 | Port C pin inputs |
| pc_out | output | 6 | Port C output values |
| pc_oe | output | 6 | Port C per-bit output enable |

## Verification
The assertions take two things for granted:

- A control write never lands in the same cycle as a strobe edge or a port access whose result they check.
- The strobe pins are already synchronous to the clock.

The stimulus meets both conditions. It changes every input half a cycle away from the sampling edge. It holds each strobe low for a full cycle between idle-high periods. It leaves idle cycles between control writes, strobes and port reads.

// File: rtl/ppio_ctrl.sv
module ppio_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       timer_stat,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic       pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic       pb_oe,
  input  logic [5:0] pc_in,
  output logic [5:0] pc_out,
  output logic [5:0] pc_oe
);

  logic [5:0] ctrl;
  logic [5:0] pc_reg;
  logic [7:0] preg [2];
  logic [7:0] lat  [2];
  logic [1:0] bf, intr, stb_q, fall;

  wire       dir_a = ctrl[0];
  wire       dir_b = ctrl[1];
  wire [1:0] pcm   = ctrl[3:2];
  wire       ie_b  = ctrl[4];
  wire       ie_a  = ctrl[5];
  wire       hs_a  = (pcm == 2'b01) || (pcm == 2'b10);
  wire       hs_b  = (pcm == 2'b10);

  wire [1:0][7:0] p_in  = {pb_in, pa_in};
  wire [1:0]      p_dir = {dir_b, dir_a};
  wire [1:0]      p_hs  = {hs_b, hs_a};
  wire [1:0]      p_ie  = {ie_b, ie_a};
  wire [1:0]      p_stb = {pc_in[5], pc_in[2]};
  wire [1:0]      p_wr  = {!wr_n && sel == 3'd2, !wr_n && sel == 3'd1};
  wire [1:0]      p_rd  = {!rd_n && sel == 3'd2, !rd_n && sel == 3'd1};

  assign fall = p_hs & stb_q & ~p_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      pc_reg <= '0;
    end else begin
      if (!wr_n && sel == 3'd0) ctrl   <= din[5:0];
      if (!wr_n && sel == 3'd3) pc_reg <= din[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 2'b11;
      bf    <= '0;
      intr  <= '0;
      for (int g = 0; g < 2; g++) begin
        preg[g] <= '0;
        lat[g]  <= '0;
      end
    end else begin
      stb_q <= p_stb;
      for (int g = 0; g < 2; g++) begin
        if (p_wr[g]) preg[g] <= din;
        if (p_hs[g] && !p_dir[g]) begin
          if (p_rd[g]) begin
            bf[g]   <= 1'b0;
            intr[g] <= 1'b0;
          end
          if (fall[g]) begin
            lat[g] <= p_in[g];
            bf[g]  <= 1'b1;
            if (p_ie[g]) intr[g] <= 1'b1;
          end
        end else if (p_hs[g] && p_dir[g]) begin
          if (fall[g]) begin
            bf[g] <= 1'b0;
            if (p_ie[g]) intr[g] <= 1'b1;
          end
          if (p_wr[g]) begin
            bf[g]   <= 1'b1;
            intr[g] <= 1'b0;
          end
        end
      end
    end
  end

  assign pa_out = preg[0];
  assign pb_out = preg[1];
  assign pa_oe  = dir_a;
  assign pb_oe  = dir_b;

  always_comb begin
    case (pcm)
      2'b00:   begin pc_oe = 6'h00; pc_out = 6'h00; end
      2'b11:   begin pc_oe = 6'h3F; pc_out = pc_reg; end
      2'b01:   begin pc_oe = 6'h3B; pc_out = {pc_reg[5:3], 1'b0, bf[0], intr[0]}; end
      default: begin pc_oe = 6'h1B; pc_out = {1'b0, bf[1], intr[1], 1'b0, bf[0], intr[0]}; end
    endcase
  end

  wire [7:0] rd_a  = dir_a ? preg[0] : (hs_a ? lat[0] : pa_in);
  wire [7:0] rd_b  = dir_b ? preg[1] : (hs_b ? lat[1] : pb_in);
  wire [5:0] rd_c  = (pc_oe & pc_out) | (~pc_oe & pc_in);
  wire [7:0] stat  = {1'b0, timer_stat, ie_b, bf[1], intr[1], ie_a, bf[0], intr[0]};

  always_comb begin
    dout = 8'h00;
    if (!rd_n) begin
      case (sel)
        3'd0:    dout = stat;
        3'd1:    dout = rd_a;
        3'd2:    dout = rd_b;
        3'd3:    dout = {2'b00, rd_c};
        default: dout = 8'h00;
      endcase
    end
  end

  AST_DIR_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && sel == 3'd0) |=> (pa_oe == $past(din[0]) && pb_oe == $past(din[1]))); // R2

  AST_BF_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_a && !dir_a && fall[0] && wr_n) |=> pc_out[1]); // R6

  AST_INTR_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr[0]) |-> $past(ie_a)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && sel == 3'd1 && hs_a && !dir_a && !fall[0] && wr_n) |=> (!bf[0] && !intr[0])); // R8

  AST_IGNORED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && sel[2]) |=> ($stable(ctrl) && $stable(pa_out) && $stable(pb_out))); // R10

  AST_STATUS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && sel == 3'd0) |-> !dout[7]); // R11

  AST_PORTB_ONLY_ALT4: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm != 2'b10) |=> $stable(bf[1])); // R12

endmodule

// File: tb/sim_ppio_ctrl.sv
`timescale 1ns/1ps
module sim_ppio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = '0;
  logic       rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       timer_stat = 1'b0;
  logic [7:0] pa_in = '0, pb_in = '0;
  logic [7:0] pa_out, pb_out;
  logic       pa_oe, pb_oe;
  logic [5:0] pc_in = 6'b100100;
  logic [5:0] pc_out, pc_oe;

  always #4 clk = ~clk;

  ppio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_n(rd_n), .wr_n(wr_n), .din(din),
    .dout(dout), .timer_stat(timer_stat), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  typedef struct {
    int         src;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_run = 0, n_fail = 0;
  logic  go = 1'b0;
  bit    done = 1'b0;

  always @(negedge clk) begin
    #2;
    if (go && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.src)
        0: act = dout;
        1: act = {2'b00, pc_out};
        2: act = {2'b00, pc_oe};
        3: act = pa_out;
        4: act = pb_out;
        default: act = {6'b0, pb_oe, pa_oe};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic bus_wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); #1;
    sel = s; din = d; wr_n = 1'b0;
    @(negedge clk); #1;
    wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [2:0] s, input logic [7:0] e, input string t);
    item_t it;
    @(negedge clk); #1;
    sel = s; rd_n = 1'b0;
    it.src = 0; it.exp = e; it.tag = t;
    q.push_back(it);
    go = 1'b1;
    @(negedge clk); #1;
    rd_n = 1'b1; go = 1'b0;
  endtask

  task automatic look(input int src, input logic [7:0] e, input string t);
    item_t it;
    @(negedge clk); #1;
    it.src = src; it.exp = e; it.tag = t;
    q.push_back(it);
    go = 1'b1;
    @(negedge clk); #1;
    go = 1'b0;
  endtask

  task automatic strobe(input int b);
    @(negedge clk); #1;
    pc_in[b] = 1'b0;
    @(negedge clk); #1;
    pc_in[b] = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    look(2, 8'h00, "R1 pc_oe after reset");
    look(5, 8'h00, "R1 port A/B oe after reset");
    bus_rd(3'd0, 8'h00, "R1 status after reset");

    timer_stat = 1'b1;
    bus_rd(3'd0, 8'h40, "R11 timer bit in status");

    bus_wr(3'd0, 8'h03);
    look(5, 8'h03, "R2 both ports output");
    bus_rd(3'd0, 8'h40, "R2 select 0 read gives status");
    timer_stat = 1'b0;

    bus_wr(3'd1, 8'hA5);
    bus_wr(3'd2, 8'h3C);
    look(3, 8'hA5, "R4 port A out");
    look(4, 8'h3C, "R4 port B out");
    bus_rd(3'd1, 8'hA5, "R4 port A readback");

    bus_wr(3'd0, 8'h0C);
    look(2, 8'h3F, "R3 mode 11 all outputs");
    bus_wr(3'd3, 8'h2A);
    look(1, 8'h2A, "R4 port C out");
    bus_rd(3'd3, 8'h2A, "R5 port C driven readback");

    bus_wr(3'd0, 8'h00);
    look(2, 8'h00, "R3 mode 00 all inputs");
    pa_in = 8'h5E;
    bus_rd(3'd1, 8'h5E, "R5 port A live pins");
    pc_in = 6'h15;
    bus_rd(3'd3, 8'h15, "R5 port C live pins");
    pc_in = 6'b100100;

    bus_wr(3'd4, 8'hFF);
    bus_wr(3'd6, 8'h3F);
    bus_rd(3'd4, 8'h00, "R10 select 4 reads zero");
    bus_rd(3'd6, 8'h00, "R10 select 6 reads zero");
    look(3, 8'hA5, "R10 port A out untouched");
    bus_rd(3'd0, 8'h00, "R10 control untouched");

    bus_wr(3'd0, 8'h24);
    look(2, 8'h3B, "R3 mode 01 enables");
    pa_in = 8'h77;
    strobe(2);
    look(1, 8'h2B, "R6 pc_out flags after strobe");
    bus_rd(3'd0, 8'h07, "R7 status intr with enable");
    pa_in = 8'h00;
    bus_rd(3'd1, 8'h77, "R6 latched data");
    bus_rd(3'd0, 8'h04, "R8 read clears flags");
    look(1, 8'h28, "R8 pc_out flags cleared");

    bus_wr(3'd0, 8'h04);
    strobe(2);
    bus_rd(3'd0, 8'h02, "R7 no intr without enable");
    bus_rd(3'd1, 8'h00, "R6 latched zero byte");
    bus_rd(3'd0, 8'h00, "R8 buffer-full cleared");

    strobe(5);
    bus_rd(3'd0, 8'h00, "R12 PC5 ignored in mode 01");

    bus_wr(3'd0, 8'h18);
    look(2, 8'h1B, "R3 mode 10 enables");
    pb_in = 8'hC3;
    strobe(5);
    bus_rd(3'd0, 8'h38, "R7 port B flags");
    pb_in = 8'h11;
    bus_rd(3'd2, 8'hC3, "R6 port B latched");
    bus_rd(3'd0, 8'h20, "R8 port B cleared");

    bus_wr(3'd0, 8'h29);
    bus_wr(3'd1, 8'h99);
    bus_rd(3'd0, 8'h06, "R9 write sets buffer-full");
    strobe(2);
    bus_rd(3'd0, 8'h05, "R9 strobe acknowledges");
    bus_wr(3'd1, 8'h11);
    bus_rd(3'd0, 8'h06, "R9 write clears intr");
    look(3, 8'h11, "R9 output data");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_run++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule